// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits beside a UART transmitter and drives the direction-enable pin of an RS-485 line transceiver. It sees every push into the transmit FIFO and claims the bus at once. It then tracks the FIFO-empty flag and the shift-register idle flag. When the last stop bit of the last queued byte has left the line, it hands the bus back. The hand-back can be delayed by a tail of 0 to 255 bit times, counted with a one-bit-time tick that the baud generator supplies.

The block takes two static inputs. A control word holds the auto-direction enable and a polarity-invert bit, plus three other RS-485 feature enables that belong to other logic. An 8-bit word holds the tail length. By default the pin is driven low while the transmitter owns the bus and high when it is idle.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset, with any control word, dir_o is at the idle level and the controller holds no claim on the bus.
- R2: With auto-direction enabled (control bit 4 = 1), a cycle with fifo_wr_i = 1 makes dir_o active from the next clock edge.
- R3: Once claimed, dir_o stays active until the transmitter has first reported activity (fifo_empty_i = 0 or shift_idle_i = 0). It then stays active until both fifo_empty_i = 1 and shift_idle_i = 1 are seen. Reporting idle right after the write, before any activity, does not release it.
- R4: With a tail length of 0, dir_o returns to idle on the clock edge where both idle flags are first seen after activity.
- R5: With a tail length N > 0, dir_o stays active after the idle report and returns to idle on the edge that samples the Nth bit_tick_i pulse. Cycles without a tick do not advance the tail.
- R6: The tail length is captured when the tail starts. A change to delay_i during a tail has no effect until the next tail.
- R7: A FIFO write during a tail cancels it. dir_o stays active in every cycle with no idle glitch, and the next release runs a full tail again.
- R8: With control bit 5 = 0, the active level of dir_o is 0 and the idle level is 1. With bit 5 = 1, the active level is 1 and the idle level is 0.
- R9: With control bit 4 = 0, dir_o is at the idle level from the next edge whatever the transmitter does, including mid-transfer. Control bits 0 to 3 (multidrop, receiver-off, address-detect, spare) have no effect on dir_o.
- R10: The largest tail length, 255, holds dir_o active through 254 ticks and releases it on the 255th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_wr_i | input | 1 | Write strobe into the transmit FIFO |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| shift_idle_i | input | 1 | Shift register idle, last stop bit sent |
| bit_tick_i | input | 1 | One-cycle pulse once per bit time |
| ctrl_i | input | 8 | RS-485 control word (bit 4 auto-direction, bit 5 invert) |
| delay_i | input | 8 | Tail length in bit times |
| dir_o | output | 1 | Transceiver direction enable |

## Verification
The hardest case to reach is a write that lands inside a running tail. The bench has to drive the transmitter flags through a full busy-then-idle cycle, feed only part of the tail ticks, and then pulse the write strobe. It samples dir_o in every cycle around that write to catch a one-cycle glitch. A second release then has to run the full tail again. The same pattern is used to show that a delay change made mid-tail is ignored. In that test the new value is applied after the tail has started, and the ticks are counted against the old value.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_TAIL = 2'd2
  } dir_state_e;

  typedef struct packed {
    logic auto_dir;
    logic invert;
  } dir_cfg_t;

endpackage

// File: rtl/rs485_ctrl_decode.sv
module rs485_ctrl_decode
  import rs485_dir_pkg::*;
#(
  parameter int CTRL_W       = 8,
  parameter int AUTO_DIR_BIT = 4,
  parameter int INVERT_BIT   = 5
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output dir_cfg_t          cfg_o
);
  localparam logic [CTRL_W-1:0] UsedMask =
    (CTRL_W'(1) << AUTO_DIR_BIT) | (CTRL_W'(1) << INVERT_BIT);

  // remaining feature enables belong to other logic
  logic ctrl_unused;
  assign ctrl_unused = ^(ctrl_i & ~UsedMask);

  assign cfg_o.auto_dir = ctrl_i[AUTO_DIR_BIT];
  assign cfg_o.invert   = ctrl_i[INVERT_BIT];
endmodule

// File: rtl/rs485_tail_timer.sv
module rs485_tail_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             expire_o
);
  localparam logic [DLY_W-1:0] One = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q && tick_i && !stop_i && (cnt_q == One);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= delay_i;
      run_q <= 1'b1;
    end else if (stop_i || expire_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - One;
    end
  end

  p_load_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(delay_i)));

  p_no_tick_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !tick_i && !load_i && !stop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic empty_i,
  input  logic shift_idle_i,
  input  logic zero_dly_i,
  input  logic expire_i,
  output logic load_o,
  output logic stop_o,
  output logic active_o
);
  dir_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       line_idle;

  assign line_idle = empty_i && shift_idle_i;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    load_o  = 1'b0;
    stop_o  = 1'b0;
    if (!en_i) begin
      state_d = DIR_IDLE;
      armed_d = 1'b0;
      stop_o  = (state_q == DIR_TAIL);
    end else begin
      unique case (state_q)
        DIR_IDLE: if (wr_i) begin
          state_d = DIR_SEND;
          armed_d = 1'b0;
        end
        DIR_SEND: begin
          if (wr_i) begin
            armed_d = 1'b0;
          end else if (!line_idle) begin
            armed_d = 1'b1;
          end else if (armed_q) begin
            armed_d = 1'b0;
            if (zero_dly_i) state_d = DIR_IDLE;
            else begin
              state_d = DIR_TAIL;
              load_o  = 1'b1;
            end
          end
        end
        DIR_TAIL: begin
          if (wr_i) begin
            state_d = DIR_SEND;
            armed_d = 1'b0;
            stop_o  = 1'b1;
          end else if (expire_i) begin
            state_d = DIR_IDLE;
          end
        end
        default: state_d = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIR_IDLE;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign active_o = (state_q != DIR_IDLE);

  p_write_claims_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> (state_q == DIR_SEND));

  p_busy_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == DIR_SEND && !line_idle) |=> (state_q == DIR_SEND));

  p_unarmed_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == DIR_SEND && !armed_q) |=> (state_q == DIR_SEND));

  p_zero_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == DIR_SEND && armed_q && line_idle && !wr_i && zero_dly_i)
      |=> (state_q == DIR_IDLE));

  p_tail_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == DIR_TAIL && wr_i) |=> (state_q == DIR_SEND));

  p_disabled_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == DIR_IDLE));
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int CTRL_W       = 8,
  parameter int DLY_W        = 8,
  parameter int AUTO_DIR_BIT = 4,
  parameter int INVERT_BIT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_wr_i,
  input  logic              fifo_empty_i,
  input  logic              shift_idle_i,
  input  logic              bit_tick_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              dir_o
);
  dir_cfg_t cfg;
  logic     load, stop, expire, active, zero_dly;

  assign zero_dly = (delay_i == '0);

  rs485_ctrl_decode #(
    .CTRL_W      (CTRL_W),
    .AUTO_DIR_BIT(AUTO_DIR_BIT),
    .INVERT_BIT  (INVERT_BIT)
  ) u_decode (
    .ctrl_i(ctrl_i),
    .cfg_o (cfg)
  );

  rs485_dir_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cfg.auto_dir),
    .wr_i        (fifo_wr_i),
    .empty_i     (fifo_empty_i),
    .shift_idle_i(shift_idle_i),
    .zero_dly_i  (zero_dly),
    .expire_i    (expire),
    .load_o      (load),
    .stop_o      (stop),
    .active_o    (active)
  );

  rs485_tail_timer #(.DLY_W(DLY_W)) u_tail (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .stop_i  (stop),
    .tick_i  (bit_tick_i),
    .delay_i (delay_i),
    .expire_o(expire)
  );

  // default: active low
  assign dir_o = ~(active ^ cfg.invert);

  p_expire_in_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> (active && !load));
endmodule

// File: tb/rs485_dir_ctrl_test.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, empty = 1'b1, sidle = 1'b1, tick = 1'b0;
  logic [7:0] ctrl = 8'h00, dly = 8'h00;
  logic       dir;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  localparam logic [7:0] AUTO = 8'h10;
  localparam logic [7:0] INV  = 8'h20;

  always #10 clk = ~clk;

  rs485_dir_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_wr_i(wr), .fifo_empty_i(empty),
    .shift_idle_i(sidle), .bit_tick_i(tick), .ctrl_i(ctrl), .delay_i(dly),
    .dir_o(dir)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dir_o=%b expected %b", req, act, exp);
    end
  endtask

  // write, go busy, go idle; returns just after the idle-sampling edge
  task automatic frame(input logic act_lvl, input string req);
    wr = 1'b1; step(); wr = 1'b0;
    chk(dir, act_lvl, req);
    empty = 1'b0; sidle = 1'b0; step();
    chk(dir, act_lvl, req);
    empty = 1'b1; step();
    chk(dir, act_lvl, req);
    sidle = 1'b1; step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk(dir, 1'b1, "R1 reset idle level");
    ctrl = AUTO | INV; step();
    chk(dir, 1'b0, "R1 reset idle level inverted");
    ctrl = AUTO; step();
    chk(dir, 1'b1, "R1 idle after reset");
  endtask

  task automatic t_zero_delay;
    ctrl = AUTO; dly = 8'd0;
    frame(1'b0, "R2 claim on write");
    chk(dir, 1'b1, "R4 zero tail release");
  endtask

  task automatic t_unarmed;
    ctrl = AUTO; dly = 8'd0;
    wr = 1'b1; step(); wr = 1'b0;
    step(3);
    chk(dir, 1'b0, "R3 idle flags before activity ignored");
    sidle = 1'b0; step(2);
    chk(dir, 1'b0, "R3 hold while shifting");
    sidle = 1'b1; step();
    chk(dir, 1'b1, "R3 release after activity");
  endtask

  task automatic t_tail;
    ctrl = AUTO; dly = 8'd3;
    frame(1'b0, "R5 active during frame");
    chk(dir, 1'b0, "R5 tail started");
    step(4);
    chk(dir, 1'b0, "R5 no tick no advance");
    ticks(2);
    chk(dir, 1'b0, "R5 after 2 of 3 ticks");
    step(2);
    ticks(1);
    chk(dir, 1'b1, "R5 release on 3rd tick");
  endtask

  task automatic t_sample;
    ctrl = AUTO; dly = 8'd4;
    frame(1'b0, "R6 frame");
    dly = 8'd1;
    ticks(1);
    chk(dir, 1'b0, "R6 mid-tail delay change ignored");
    ticks(2);
    chk(dir, 1'b0, "R6 old length still counting");
    ticks(1);
    chk(dir, 1'b1, "R6 release on 4th tick");
    frame(1'b0, "R6 next frame");
    ticks(1);
    chk(dir, 1'b1, "R6 new length on next tail");
  endtask

  task automatic t_cancel;
    bit glitch;
    ctrl = AUTO; dly = 8'd5;
    frame(1'b0, "R7 frame");
    ticks(3);
    glitch = 1'b0;
    tick = 1'b1; wr = 1'b1; step(); wr = 1'b0; tick = 1'b0;
    if (dir !== 1'b0) glitch = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (dir !== 1'b0) glitch = 1'b1;
    end
    chk(glitch, 1'b0, "R7 no glitch on cancel");
    empty = 1'b0; step(); empty = 1'b1; step();
    ticks(4);
    chk(dir, 1'b0, "R7 full tail restarted");
    ticks(1);
    chk(dir, 1'b1, "R7 release after full tail");
  endtask

  task automatic t_polarity;
    ctrl = AUTO | INV; dly = 8'd0; step();
    chk(dir, 1'b0, "R8 inverted idle level");
    frame(1'b1, "R8 inverted active level");
    chk(dir, 1'b0, "R8 inverted release");
  endtask

  task automatic t_disable;
    ctrl = 8'h0F; dly = 8'd0;
    wr = 1'b1; step(); wr = 1'b0;
    chk(dir, 1'b1, "R9 disabled ignores write");
    empty = 1'b0; sidle = 1'b0; step(2);
    chk(dir, 1'b1, "R9 disabled ignores busy line");
    ctrl = AUTO | 8'h0F; empty = 1'b1; sidle = 1'b1; step();
    wr = 1'b1; step(); wr = 1'b0;
    chk(dir, 1'b0, "R9 low bits no effect on claim");
    empty = 1'b0; step();
    ctrl = 8'h0F; step();
    chk(dir, 1'b1, "R9 disable mid-transfer");
    empty = 1'b1; ctrl = AUTO; step();
    chk(dir, 1'b1, "R9 re-enable stays idle");
  endtask

  task automatic t_max;
    ctrl = AUTO; dly = 8'd255;
    frame(1'b0, "R10 frame");
    ticks(254);
    chk(dir, 1'b0, "R10 active after 254 ticks");
    ticks(1);
    chk(dir, 1'b1, "R10 release on 255th tick");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    t_reset_pre();
    rst_n = 1'b1;
    step();
    t_reset();
    t_zero_delay();
    t_unarmed();
    t_tail();
    t_sample();
    t_cancel();
    t_polarity();
    t_disable();
    t_max();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic t_reset_pre;
    chk(dir, 1'b1, "R1 idle level in reset");
  endtask
endmodule